// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block is a real-time clock peripheral that sits on a simple 32-bit word-access register bus. The bus carries a byte address, a write enable, write data and read data. A prescaler divides the system clock down to a one-second tick. While the clock is started, each tick advances an internal seconds count. Software never reads that count directly. It reads the sum of the count and a software-written load value, so the epoch can be set without stopping the counter.

An alarm register is compared against that sum each time the count advances. On equality a sticky raw status bit is set. The raw status drives a single interrupt line through a mask bit, and software clears it with a write of 1 to a clear register. Any write to the control register zeroes the internal count, even when the start bit keeps its value. A fixed block of identification bytes sits at the top of the 4 KiB register window.

Register word offsets (byte address, bits [1:0] ignored):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read-only | count plus load |
| 0x04 | read/write | alarm value |
| 0x08 | read/write | load value |
| 0x0C | read/write | bit 0: start |
| 0x10 | read/write | bit 0: mask (1 hides the interrupt) |
| 0x14 | read-only | bit 0: raw status |
| 0x18 | read-only | bit 0: masked status |
| 0x1C | write-only | bit 0: clear raw status |

Top module: `tick_rtc`

## Requirements
- R1: After reset, the count, alarm, load, start, mask and raw status are all zero, every mapped register reads 0 and `alarm_irq` is low.
- R2: A read at 0x00 returns the internal count plus the load register, modulo 2^32.
- R3: While start (bit 0 at 0x0C) is 1, the count rises by exactly one every TICKS_PER_SEC clocks. While start is 0, it does not change.
- R4: Any write to 0x0C zeroes the count, whatever the data is and whether or not the start bit changes.
- R5: A write that takes start from 0 to 1 begins a full interval. The first increment lands at the TICKS_PER_SEC-th clock edge after the write edge.
- R6: When an increment makes count plus load equal to the alarm register (0x04), raw status (bit 0 at 0x14) becomes 1 at that same edge and stays at 1 until it is cleared.
- R7: A write to 0x1C with bit 0 set clears raw status at the write edge, and a write with bit 0 clear has no effect. If an alarm match happens at the same edge as the clear, the match wins and raw status ends at 1.
- R8: Masked status (bit 0 at 0x18) and `alarm_irq` equal raw status AND NOT the mask (bit 0 at 0x10). Both follow a mask write at the write edge.
- R9: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x31, 0x10, 0x04 and 0x00. Reads at 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x0D, 0xF0, 0x05 and 0xB1.
- R10: Reads of 0x1C and of any unmapped offset return 0. Writes to 0x00, 0x14, 0x18 and unmapped offsets change no state.
- R11: The alarm and load registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write enable, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Interrupt line, masked alarm status |

## Verification
The bench builds the block with TICKS_PER_SEC set to 8. With that value a second takes only eight clocks, so the bench can observe an exact first-increment edge, several seconds of counting, a halt, and a wrap of the sum past 2^32. It can also land a clear write on the very edge where an alarm match occurs. ADDR_W stays at 12, so the identification bytes at the top of the window and the unmapped offsets between them and the live registers are all reachable.

// File: rtl/tick_rtc_pkg.sv
package tick_rtc_pkg;

  localparam int RTC_W = 32;
  typedef logic [RTC_W-1:0] rtc_word_t;

  // word indices of the live registers (byte offset / 4)
  localparam int W_TIME  = 0;
  localparam int W_ALARM = 1;
  localparam int W_LOAD  = 2;
  localparam int W_CTRL  = 3;
  localparam int W_MASK  = 4;
  localparam int W_RAW   = 5;
  localparam int W_MIS   = 6;
  localparam int W_CLR   = 7;

  // number of identification words at the top of the window
  localparam int ID_WORDS = 8;

  typedef struct packed {
    logic alarm;
    logic load;
    logic ctrl;
    logic mask;
    logic clr;
  } wr_strobe_t;

  // visible time: internal count plus software offset
  function automatic rtc_word_t rtc_view(input rtc_word_t count, input rtc_word_t offset);
    return count + offset;
  endfunction

  // count value after one tick
  function automatic rtc_word_t rtc_step(input rtc_word_t count);
    return count + rtc_word_t'(1);
  endfunction

  // interrupt level from sticky status and hide bit
  function automatic logic irq_level(input logic raw, input logic hide);
    return raw & ~hide;
  endfunction

  // identification byte for the idx-th word of the ID block
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/tick_rtc_prescale.sv
module tick_rtc_prescale #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  generate
    if (TICKS_PER_SEC <= 1) begin : g_every
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tick = run;
    end else begin : g_div
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
      logic [CNT_W-1:0] cnt_q;

      // held at zero while stopped so a start always begins a full interval
      always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run)         cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CNT_W'(1);
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/tick_rtc_decode.sv
module tick_rtc_decode
  import tick_rtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WIDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wr_strobe_t        strb,
  output logic [WIDX_W-1:0] widx
);

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    strb       = '0;
    strb.alarm = wr && (widx == WIDX_W'(W_ALARM));
    strb.load  = wr && (widx == WIDX_W'(W_LOAD));
    strb.ctrl  = wr && (widx == WIDX_W'(W_CTRL));
    strb.mask  = wr && (widx == WIDX_W'(W_MASK));
    strb.clr   = wr && (widx == WIDX_W'(W_CLR));
  end

endmodule

// File: rtl/tick_rtc_core.sv
module tick_rtc_core
  import tick_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wr_strobe_t strb,
  input  rtc_word_t  wdata,
  input  logic       tick,
  output rtc_word_t  view,
  output rtc_word_t  alarm,
  output rtc_word_t  offset,
  output rtc_word_t  count,
  output logic       run,
  output logic       hide,
  output logic       raw,
  output logic       irq,
  output logic       match_hit,
  output logic       clr_hit
);

  rtc_word_t count_q, alarm_q, offset_q;
  logic      run_q, hide_q, raw_q;
  logic      step_ok;

  // a control write owns the count in its cycle, a tick is dropped then
  assign step_ok   = tick && !strb.ctrl;
  assign match_hit = step_ok && (rtc_view(rtc_step(count_q), offset_q) == alarm_q);
  assign clr_hit   = strb.clr && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      alarm_q  <= '0;
      offset_q <= '0;
      run_q    <= 1'b0;
      hide_q   <= 1'b0;
      raw_q    <= 1'b0;
    end else begin
      if (strb.alarm) alarm_q  <= wdata;
      if (strb.load)  offset_q <= wdata;
      if (strb.mask)  hide_q   <= wdata[0];

      if (strb.ctrl) begin
        run_q   <= wdata[0];
        count_q <= '0;
      end else if (step_ok) begin
        count_q <= rtc_step(count_q);
      end

      if (match_hit)    raw_q <= 1'b1;
      else if (clr_hit) raw_q <= 1'b0;
    end
  end

  assign view   = rtc_view(count_q, offset_q);
  assign alarm  = alarm_q;
  assign offset = offset_q;
  assign count  = count_q;
  assign run    = run_q;
  assign hide   = hide_q;
  assign raw    = raw_q;
  assign irq    = irq_level(raw_q, hide_q);

endmodule

// File: rtl/tick_rtc_readmux.sv
module tick_rtc_readmux
  import tick_rtc_pkg::*;
#(
  parameter int WIDX_W = 10
) (
  input  logic [WIDX_W-1:0] widx,
  input  rtc_word_t         view,
  input  rtc_word_t         alarm,
  input  rtc_word_t         offset,
  input  logic              run,
  input  logic              hide,
  input  logic              raw,
  output rtc_word_t         rdata
);

  localparam int ID_SEL_W = $clog2(ID_WORDS);

  logic in_id;
  assign in_id = (widx[WIDX_W-1:ID_SEL_W] == '1);

  always_comb begin
    rdata = '0;
    if (in_id) begin
      rdata = rtc_word_t'(id_byte(widx[ID_SEL_W-1:0]));
    end else begin
      case (widx)
        WIDX_W'(W_TIME):  rdata = view;
        WIDX_W'(W_ALARM): rdata = alarm;
        WIDX_W'(W_LOAD):  rdata = offset;
        WIDX_W'(W_CTRL):  rdata = rtc_word_t'(run);
        WIDX_W'(W_MASK):  rdata = rtc_word_t'(hide);
        WIDX_W'(W_RAW):   rdata = rtc_word_t'(raw);
        WIDX_W'(W_MIS):   rdata = rtc_word_t'(irq_level(raw, hide));
        default:          rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tick_rtc.sv
module tick_rtc
  import tick_rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 50_000_000,
  parameter int          ADDR_W        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_irq
);

  localparam int WIDX_W = ADDR_W - 2;

  wr_strobe_t        wr_strb;
  logic [WIDX_W-1:0] word_idx;
  logic              sec_tick;
  rtc_word_t         time_view, alarm_val, load_val, sec_count;
  logic              run_bit, hide_bit, raw_bit;
  logic              match_hit, clr_hit;

  tick_rtc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .strb (wr_strb),
    .widx (word_idx)
  );

  tick_rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_bit),
    .tick  (sec_tick)
  );

  tick_rtc_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (wr_strb),
    .wdata     (bus_wdata),
    .tick      (sec_tick),
    .view      (time_view),
    .alarm     (alarm_val),
    .offset    (load_val),
    .count     (sec_count),
    .run       (run_bit),
    .hide      (hide_bit),
    .raw       (raw_bit),
    .irq       (alarm_irq),
    .match_hit (match_hit),
    .clr_hit   (clr_hit)
  );

  tick_rtc_readmux #(.WIDX_W(WIDX_W)) u_readmux (
    .widx   (word_idx),
    .view   (time_view),
    .alarm  (alarm_val),
    .offset (load_val),
    .run    (run_bit),
    .hide   (hide_bit),
    .raw    (raw_bit),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/tick_rtc_chk.sv
module tick_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        run,
  input logic        ctrl_wr,
  input logic        match_hit,
  input logic        clr_hit,
  input logic [31:0] count,
  input logic        raw,
  input logic        hide,
  input logic        irq
);

  assert_halt_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_wr) |=> (count == $past(count)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr) |=> (count == 32'($past(count) + 32'd1)));

  assert_ctrl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (count == 32'd0));

  assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> raw);

  assert_raw_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(match_hit));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !match_hit) |=> !raw);

  assert_hidden_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hide |-> !irq);

  assert_irq_needs_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw);

endmodule

bind tick_rtc tick_rtc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (sec_tick),
  .run       (run_bit),
  .ctrl_wr   (wr_strb.ctrl),
  .match_hit (match_hit),
  .clr_hit   (clr_hit),
  .count     (sec_count),
  .raw       (raw_bit),
  .hide      (hide_bit),
  .irq       (alarm_irq)
);

// File: tb/sim_tick_rtc.sv
module sim_tick_rtc;

  localparam int CLK_PERIOD = 10;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_rtc #(.TICKS_PER_SEC(T), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 time", 12'h000, 0);
    expect_reg("R1 alarm", 12'h004, 0);
    expect_reg("R1 load", 12'h008, 0);
    idle(1);
    expect_reg("R1 ctrl", 12'h00C, 0);
    expect_reg("R1 mask", 12'h010, 0);
    expect_reg("R1 raw", 12'h014, 0);
    idle(1);
    expect_reg("R1 mis", 12'h018, 0);
    check("R1 irq", 32'(alarm_irq), 0);
  endtask

  task automatic t_regs;
    bus_write(12'h004, 32'hA5A5_1234);
    expect_reg("R11 alarm readback", 12'h004, 32'hA5A5_1234);
    bus_write(12'h008, 32'h0000_1000);
    expect_reg("R11 load readback", 12'h008, 32'h0000_1000);
    expect_reg("R2 stopped time equals load", 12'h000, 32'h0000_1000);
    bus_write(12'h000, 32'h0000_FFFF);
    expect_reg("R10 time write ignored", 12'h000, 32'h0000_1000);
    bus_write(12'h014, 32'h1);
    expect_reg("R10 raw write ignored", 12'h014, 0);
    bus_write(12'h018, 32'h1);
    expect_reg("R10 mis write ignored", 12'h018, 0);
    check("R10 irq after ignored writes", 32'(alarm_irq), 0);
    expect_reg("R10 clear reads zero", 12'h01C, 0);
    bus_write(12'h040, 32'hDEAD_BEEF);
    expect_reg("R10 unmapped read 0x040", 12'h040, 0);
    expect_reg("R10 alarm kept", 12'h004, 32'hA5A5_1234);
    idle(1);
    expect_reg("R10 load kept", 12'h008, 32'h0000_1000);
    expect_reg("R10 unmapped read 0x7FC", 12'h7FC, 0);
  endtask

  task automatic t_ids;
    logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      expect_reg("R9 id byte", 12'hFE0 + 12'(4*i), 32'(ids[i]));
      idle(1);
    end
  endtask

  task automatic t_start_timing;
    bus_write(12'h00C, 32'h1);
    idle(T-1);
    expect_reg("R5 no increment before full interval", 12'h000, 32'h0000_1000);
    idle(1);
    expect_reg("R5 first increment at interval", 12'h000, 32'h0000_1001);
    idle(4*T);
    expect_reg("R3 five seconds counted", 12'h000, 32'h0000_1005);
    expect_reg("R3 start reads back", 12'h00C, 32'h1);
  endtask

  task automatic t_ctrl_clear;
    bus_write(12'h00C, 32'hFFFF_FFFF);
    expect_reg("R4 ctrl write with start kept zeroes count", 12'h000, 32'h0000_1000);
    expect_reg("R4 start still set", 12'h00C, 32'h1);
    idle(2*T);
    bus_write(12'h00C, 32'h0);
    expect_reg("R4 stop write zeroes count", 12'h000, 32'h0000_1000);
    idle(3*T);
    expect_reg("R3 halted count unchanged", 12'h000, 32'h0000_1000);
    expect_reg("R3 start reads clear", 12'h00C, 0);
  endtask

  task automatic t_wrap;
    bus_write(12'h008, 32'hFFFF_FFFE);
    bus_write(12'h00C, 32'h1);
    idle(3*T);
    expect_reg("R2 sum wraps modulo 2^32", 12'h000, 32'h0000_0001);
    bus_write(12'h00C, 32'h0);
  endtask

  task automatic t_match;
    bus_write(12'h004, 32'd103);
    bus_write(12'h008, 32'd100);
    bus_write(12'h00C, 32'h1);
    idle(2*T);
    expect_reg("R6 raw clear before match", 12'h014, 0);
    check("R6 irq low before match", 32'(alarm_irq), 0);
    idle(T);
    expect_reg("R6 raw set at match", 12'h014, 1);
    expect_reg("R6 time at match", 12'h000, 32'd103);
    expect_reg("R8 masked status follows raw", 12'h018, 1);
    check("R8 irq high on match", 32'(alarm_irq), 1);
    idle(T);
    expect_reg("R6 raw sticky", 12'h014, 1);
    bus_write(12'h00C, 32'h0);
  endtask

  task automatic t_mask;
    bus_write(12'h010, 32'h1);
    check("R8 irq drops on mask write", 32'(alarm_irq), 0);
    expect_reg("R8 masked status hidden", 12'h018, 0);
    expect_reg("R8 raw unaffected by mask", 12'h014, 1);
    bus_write(12'h010, 32'h0);
    check("R8 irq returns on unmask", 32'(alarm_irq), 1);
  endtask

  task automatic t_clear;
    bus_write(12'h01C, 32'hFFFF_FFFE);
    expect_reg("R7 clear with bit0 low ignored", 12'h014, 1);
    bus_write(12'h01C, 32'h1);
    expect_reg("R7 clear drops raw", 12'h014, 0);
    check("R7 irq low after clear", 32'(alarm_irq), 0);
  endtask

  task automatic t_clear_priority;
    bus_write(12'h004, 32'd101);
    bus_write(12'h008, 32'd100);
    bus_write(12'h00C, 32'h1);
    idle(T-1);
    bus_write(12'h01C, 32'h1);
    expect_reg("R7 match wins over clear", 12'h014, 1);
    expect_reg("R7 time at priority edge", 12'h000, 32'd101);
    bus_write(12'h00C, 32'h0);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regs();
    t_ids();
    t_start_timing();
    t_ctrl_clear();
    t_wrap();
    t_match();
    t_mask();
    t_clear();
    t_clear_priority();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule